// File: doc/BRIEF.md
# Bit-Serial Round-Key Generator for a 32-Bit-Block, 64-Bit-Key Lightweight Feistel Cipher

This block expands a 64-bit cipher key into the 32 sixteen-bit round keys of a lightweight Feistel cipher. The key arrives as four 16-bit words. The first four round keys are those words unchanged. Each later word is formed from the words four places and one place behind it, from two right rotations of the word just before it, from an inverting constant, and from one bit of a fixed 62-bit constant sequence. The block produces the keys one bit per clock, least significant bit first, so that a bit-serial round datapath can consume key bit j of round r in the same cycle that it processes data bit j.

The four current words sit in four 16-bit serial registers that shift one place per cycle. Every sixteen cycles the oldest word drops out and a freshly computed word takes its place at the top. Two taps on the top register supply the rotate-by-3 and rotate-by-4 terms. These taps wrap around into the four lowest bits of the word. During the first four bit times of each word, the top register therefore rotates in place and keeps its old bits, and the new bits go into a four-entry side register. At the end of the word those four bits are merged back into the top register. A software-free controller counts bit times and rounds and presents the round and bit indices beside each key bit.

Top module: `simon_keysched`

## Requirements
- R1: After reset, `kbit_valid_o` is 0, `round_o` is 0 and `bit_idx_o` is 0.
- R2: A `load_i` pulse while idle captures `key_i`. Word w of the key is `key_i[16*w+15:16*w]`, and this word is the round key of round w for w = 0 to 3.
- R3: A `start_i` pulse while idle starts a run. `kbit_valid_o` is 1 from the next cycle for exactly 512 cycles and then returns to 0. During the run `bit_idx_o` counts 0 to 15 and `round_o` rises by one at each wrap, from 0 to 31.
- R4: While `kbit_valid_o` is 1, `kbit_o` equals bit `bit_idx_o` of the round key of round `round_o`.
- R5: For rounds i+4 with i = 0 to 27, the key is K[i] ^ 0xFFFC ^ t ^ rotr(t,1) ^ z. Here t = rotr(K[i+3],3) ^ K[i+1]. The term z is bit i of the 64-bit constant 0x19C3522FB386A45F (bit 0 is the LSB), and it is placed in bit 0 of the word only.
- R6: `load_i` asserted during a run has no effect on the remaining key bits.
- R7: `start_i` asserted during a run, including in its last cycle, neither restarts nor extends the run.
- R8: When `load_i` and `start_i` are asserted in the same idle cycle, the run uses the key loaded in that cycle.
- R9: The four-entry side register is written only during bit times 0 to 3 of each word. The word it completes is still correct in the bits that need the wrapped rotation taps (bits 12 to 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture `key_i` when idle |
| key_i | input | 64 | Cipher key, word 0 in the low 16 bits |
| start_i | input | 1 | Begin a 512-cycle key stream when idle |
| kbit_valid_o | output | 1 | Key bit stream active |
| kbit_o | output | 1 | Current round-key bit |
| round_o | output | 5 | Round index of `kbit_o` |
| bit_idx_o | output | 4 | Bit position of `kbit_o` in its round key |

## Verification
Two cases can fall in the same cycle. The first is a key load together with a start. The bench drives both in one idle cycle with a random key, and the stream it gets back must match the reference schedule of that new key, not the old one. The second is a load or a start that arrives while a run is in progress. The bench injects a foreign key load in mid-run, a start pulse in mid-run, and a start pulse in the final busy cycle. It then requires that every round key still matches the original key and that valid falls exactly 512 cycles after the start.

// File: rtl/simon_ks_pkg.sv
`timescale 1ns/1ps
package simon_ks_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned KEY_WORDS  = 4;
  localparam int unsigned NUM_ROUNDS = 32;
  localparam int unsigned ROT_A      = 3;
  localparam int unsigned ROT_B      = 4;
  // z sequence for the 4-word, 16-bit variant, bit i used by generated word i+4
  localparam logic [63:0] Z_SEQ = 64'h19C3522FB386A45F;
endpackage

// File: rtl/ks_seq.sv
`timescale 1ns/1ps
module ks_seq #(
  parameter int unsigned WORD_W     = simon_ks_pkg::WORD_W,
  parameter int unsigned NUM_ROUNDS = simon_ks_pkg::NUM_ROUNDS,
  localparam int unsigned BIT_W   = $clog2(WORD_W),
  localparam int unsigned ROUND_W = $clog2(NUM_ROUNDS),
  localparam int unsigned TOTAL   = NUM_ROUNDS * WORD_W,
  localparam int unsigned CNT_W   = $clog2(TOTAL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               busy_o,
  output logic [ROUND_W-1:0] round_o,
  output logic [BIT_W-1:0]   bit_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o  = busy_q;
  assign round_o = cnt_q[CNT_W-1:BIT_W];
  assign bit_o   = cnt_q[BIT_W-1:0];

  p_first_beat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (round_o == '0 && bit_o == '0));
  p_bit_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> (bit_o == BIT_W'($past(bit_o) + 1'b1)));
  p_round_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && $past(bit_o) == '1) |-> (round_o == ROUND_W'($past(round_o) + 1'b1)));
  p_span_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(round_o) == '1 && $past(bit_o) == '1));
  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !(round_o == '1 && bit_o == '1)) |=> busy_q);
endmodule

// File: rtl/ks_store.sv
`timescale 1ns/1ps
module ks_store #(
  parameter int unsigned WORD_W    = simon_ks_pkg::WORD_W,
  parameter int unsigned KEY_WORDS = simon_ks_pkg::KEY_WORDS,
  parameter int unsigned ROT_A     = simon_ks_pkg::ROT_A,
  parameter int unsigned ROT_B     = simon_ks_pkg::ROT_B,
  localparam int unsigned BIT_W  = $clog2(WORD_W),
  localparam int unsigned LUT_AW = $clog2(ROT_B),
  localparam int unsigned KEY_W  = WORD_W * KEY_WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             busy_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             new_bit_i,
  output logic             old_o,
  output logic             mid_o,
  output logic             mid_next_o,
  output logic             top_a_o,
  output logic             top_b_o
);
  localparam logic [BIT_W-1:0] LUT_END  = BIT_W'(ROT_B);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] words [KEY_WORDS];
  logic [ROT_B-1:0]  lut_q;
  logic              load_ok;
  logic              in_lut_phase;

  assign load_ok      = load_i && !busy_i;
  assign in_lut_phase = bit_i < LUT_END;

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    assign words[g] = word_q;
    if (g < KEY_WORDS - 1) begin : g_mid
      // plain transfer path: take the next word's LSB at the top
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      word_q <= '0;
        else if (load_ok) word_q <= key_i[g*WORD_W +: WORD_W];
        else if (busy_i)  word_q <= {words[g+1][0], word_q[WORD_W-1:1]};
      end
    end else begin : g_top
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                word_q <= '0;
        else if (load_ok)           word_q <= key_i[g*WORD_W +: WORD_W];
        else if (busy_i) begin
          if (in_lut_phase)         word_q <= {word_q[0], word_q[WORD_W-1:1]};
          else if (bit_i == BIT_LAST) word_q <= {new_bit_i, word_q[WORD_W-1:ROT_B+1], lut_q};
          else                      word_q <= {new_bit_i, word_q[WORD_W-1:1]};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      lut_q <= '0;
    else if (busy_i && in_lut_phase)  lut_q[bit_i[LUT_AW-1:0]] <= new_bit_i;
  end

  assign old_o      = words[0][0];
  assign mid_o      = words[1][0];
  // at the last bit the wrapped bit 0 of the middle word already sits in the oldest word
  assign mid_next_o = (bit_i == BIT_LAST) ? words[0][1] : words[1][1];
  assign top_a_o    = words[KEY_WORDS-1][ROT_A];
  assign top_b_o    = words[KEY_WORDS-1][ROT_B];

  p_lut_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !in_lut_phase) |=> $stable(lut_q));
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !load_i) |=> ($stable(words[0]) && $stable(words[KEY_WORDS-1])));
endmodule

// File: rtl/ks_mix.sv
`timescale 1ns/1ps
module ks_mix #(
  parameter int unsigned WORD_W     = simon_ks_pkg::WORD_W,
  parameter int unsigned NUM_ROUNDS = simon_ks_pkg::NUM_ROUNDS,
  localparam int unsigned BIT_W   = $clog2(WORD_W),
  localparam int unsigned ROUND_W = $clog2(NUM_ROUNDS)
) (
  input  logic [ROUND_W-1:0] round_i,
  input  logic [BIT_W-1:0]   bit_i,
  input  logic               old_i,
  input  logic               mid_i,
  input  logic               mid_next_i,
  input  logic               top_a_i,
  input  logic               top_b_i,
  output logic               new_bit_o
);
  logic z_bit;
  logic c_bit;

  assign z_bit = simon_ks_pkg::Z_SEQ[round_i] & (bit_i == '0);
  // inversion with the low two bits restored
  assign c_bit = bit_i >= BIT_W'(2);
  assign new_bit_o = old_i ^ c_bit ^ mid_i ^ mid_next_i ^ top_a_i ^ top_b_i ^ z_bit;

  initial begin
    assert (NUM_ROUNDS <= 66) else $error("z sequence too short for NUM_ROUNDS");
  end
endmodule

// File: rtl/simon_keysched.sv
`timescale 1ns/1ps
module simon_keysched #(
  parameter int unsigned WORD_W     = simon_ks_pkg::WORD_W,
  parameter int unsigned KEY_WORDS  = simon_ks_pkg::KEY_WORDS,
  parameter int unsigned NUM_ROUNDS = simon_ks_pkg::NUM_ROUNDS,
  localparam int unsigned BIT_W   = $clog2(WORD_W),
  localparam int unsigned ROUND_W = $clog2(NUM_ROUNDS),
  localparam int unsigned KEY_W   = WORD_W * KEY_WORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic               start_i,
  output logic               kbit_valid_o,
  output logic               kbit_o,
  output logic [ROUND_W-1:0] round_o,
  output logic [BIT_W-1:0]   bit_idx_o
);
  logic               busy;
  logic [ROUND_W-1:0] round;
  logic [BIT_W-1:0]   bit_idx;
  logic               old_bit, mid_bit, mid_next, top_a, top_b, new_bit;

  ks_seq #(.WORD_W(WORD_W), .NUM_ROUNDS(NUM_ROUNDS)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .busy_o(busy), .round_o(round), .bit_o(bit_idx)
  );

  ks_store #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_store (
    .clk_i, .rst_ni, .load_i, .key_i,
    .busy_i(busy), .bit_i(bit_idx), .new_bit_i(new_bit),
    .old_o(old_bit), .mid_o(mid_bit), .mid_next_o(mid_next),
    .top_a_o(top_a), .top_b_o(top_b)
  );

  ks_mix #(.WORD_W(WORD_W), .NUM_ROUNDS(NUM_ROUNDS)) u_mix (
    .round_i(round), .bit_i(bit_idx),
    .old_i(old_bit), .mid_i(mid_bit), .mid_next_i(mid_next),
    .top_a_i(top_a), .top_b_i(top_b), .new_bit_o(new_bit)
  );

  assign kbit_valid_o = busy;
  assign kbit_o       = old_bit;
  assign round_o      = round;
  assign bit_idx_o    = bit_idx;

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kbit_valid_o) |-> $past(start_i));
endmodule

// File: tb/simon_keysched_bench.sv
`timescale 1ns/1ps
module simon_keysched_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] key_i = '0;
  logic        start_i = 1'b0;
  logic        kbit_valid_o;
  logic        kbit_o;
  logic [4:0]  round_o;
  logic [3:0]  bit_idx_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [15:0] exp_rk [32];
  logic [15:0] got_rk [32];

  localparam logic [63:0] Z_REF = 64'h19C3522FB386A45F;

  always #2.5 clk_i = ~clk_i;

  simon_keysched u_simon_keysched (
    .clk_i, .rst_ni, .load_i, .key_i, .start_i,
    .kbit_valid_o, .kbit_o, .round_o, .bit_idx_o
  );

  function automatic logic [15:0] rotr16(input logic [15:0] x, input int n);
    return (x >> n) | (x << (16 - n));
  endfunction

  task automatic calc_ref(input logic [63:0] key);
    logic [15:0] t;
    for (int w = 0; w < 4; w++) exp_rk[w] = key[16*w +: 16];
    for (int i = 0; i < 28; i++) begin
      t = rotr16(exp_rk[i+3], 3) ^ exp_rk[i+1];
      t = t ^ rotr16(t, 1);
      exp_rk[i+4] = exp_rk[i] ^ 16'hFFFC ^ t ^ {15'd0, Z_REF[i]};
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode: 0 load then start, 1 load+start same cycle; inject: mid-run load/start
  task automatic run_key(input logic [63:0] key, input bit together, input bit inject,
                         input logic [63:0] other);
    int seq_err = 0;
    calc_ref(key);
    for (int r = 0; r < 32; r++) got_rk[r] = '0;
    @(negedge clk_i);
    load_i = 1'b1; key_i = key; start_i = together;
    @(negedge clk_i);
    load_i = 1'b0; start_i = 1'b0;
    if (!together) begin
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    for (int c = 0; c < 512; c++) begin
      if (c > 0) @(negedge clk_i);
      if (!kbit_valid_o || round_o != 5'(c / 16) || bit_idx_o != 4'(c % 16)) seq_err++;
      got_rk[c/16][c%16] = kbit_o;
      if (inject) begin
        if (c == 100) begin load_i = 1'b1; key_i = other; end
        if (c == 101) load_i = 1'b0;
        if (c == 200) start_i = 1'b1;
        if (c == 201) start_i = 1'b0;
        if (c == 511) start_i = 1'b1;
      end
    end
    chk(seq_err == 0, "R3 run sequence", 64'(seq_err), 64'd0);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!kbit_valid_o, inject ? "R7 valid ends after 512 cycles" : "R3 valid ends after 512 cycles",
        64'(kbit_valid_o), 64'd0);
    for (int r = 0; r < 32; r++) begin
      if (r < 4)
        chk(got_rk[r] == exp_rk[r], $sformatf("R2 R4 round %0d", r), 64'(got_rk[r]), 64'(exp_rk[r]));
      else
        chk(got_rk[r] == exp_rk[r], $sformatf("R5/R9 R4 round %0d", r), 64'(got_rk[r]), 64'(exp_rk[r]));
    end
    if (together)
      chk(got_rk[0] == key[15:0], "R8 new key used", 64'(got_rk[0]), 64'(key[15:0]));
    if (inject) begin
      int bad = 0;
      for (int r = 0; r < 32; r++) if (got_rk[r] != exp_rk[r]) bad++;
      chk(bad == 0, "R6 mid-run load ignored", 64'(bad), 64'd0);
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk_i);
    chk(!kbit_valid_o && round_o == 0 && bit_idx_o == 0, "R1 reset state",
        {55'd0, kbit_valid_o, round_o, bit_idx_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!kbit_valid_o, "R1 idle after reset", 64'(kbit_valid_o), 64'd0);

    run_key(64'h1918_1110_0908_0100, 1'b0, 1'b0, 64'd0);
    run_key(64'h0000_0000_0000_0000, 1'b0, 1'b0, 64'd0);
    run_key(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 64'd0);
    run_key(64'h8000_0001_F00F_0FF0, 1'b0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D);
    for (int k = 0; k < 5; k++) begin
      logic [63:0] rk;
      rk = {$urandom, $urandom};
      run_key(rk, k[0], k == 3, {$urandom, $urandom});
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule